// File: doc/BRIEF.md
# Chained Multi-Stage Capture Trigger

This block watches a stream of 32-bit logic samples and decides the moment at which a capture should begin. It holds four independent trigger stages. Each stage has a compare mask, a compare value and a configuration word. A command decoder loads all three through a simple register write port. A stage compares either across all channels of the current sample (parallel mode) or across the recent history of one chosen channel (serial mode).

The stages are linked through a shared trigger level that starts at zero whenever the trigger is armed. A stage is only considered once the level has climbed to the level it was configured for. When it matches, its effect waits for a programmable number of further samples. Its effect is always to raise the level by one. If its start flag is set, it also fires a one-cycle capture-start pulse, after which the block ignores everything until it is armed again. This makes sequences possible, such as "see pattern A, then pattern B, then start".

Top module: `stage_trigger`

## Requirements
- R1: After reset `trig_level` is 0 and `capture_start` is low, and no sample causes a match effect until `arm` has been pulsed.
- R2: In parallel mode a stage matches a sample when every bit set in its mask has the same value in the sample as in its compare value; unmasked bits are ignored.
- R3: In serial mode each stage keeps a 32-bit history of its selected channel, with the newest sample in bit 0 and the sample k samples older in bit k. The stage matches when the masked history bits equal the compare value, and the history includes the current sample.
- R4: With `demux_en` high, the most significant bit of the serial channel select is ignored, so only channels 0-15 can be selected (for example, channel 19 acts as channel 3).
- R5: A stage with delay D > 0 acts on the D-th valid sample after its matching sample. Cycles without `smp_valid` are not counted. With D = 0 it acts on the matching sample itself.
- R6: A stage can match only while `trig_level` is greater than or equal to its configured level, and each stage matches at most once per arming.
- R7: A stage acting raises `trig_level` by one, saturating at 3, in the cycle after the acting sample. `capture_start` is high for that one cycle only if the acting stage has its start flag set.
- R8: Pulsing `arm` clears `trig_level` to 0, cancels pending delays and match history flags, and re-enables all stages. The cycle in which `arm` is high carries no match effect.
- R9: After `capture_start` has pulsed, further matches neither raise the level nor pulse again until the next `arm`.
- R10: With `proto_v0` high only stage 0 takes part; stages 1-3 never match.
- R11: A stage whose mask is all zeros matches on the first valid sample in which it is eligible.
- R12: A cycle with neither `smp_valid` nor `arm` leaves `trig_level` unchanged and `capture_start` low.
- R13: Register writes use `cfg_sel` 0 = mask, 1 = compare value, 2 = configuration. In the configuration word, bits [15:0] hold the delay, [17:16] the level, [24:20] the serial channel, bit 26 serial mode and bit 27 start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_stage | input | 2 | Stage addressed by the write |
| cfg_sel | input | 2 | Register selected: 0 mask, 1 value, 2 configuration |
| cfg_data | input | 32 | Write data |
| arm | input | 1 | One-cycle pulse that arms the trigger and clears the level |
| proto_v0 | input | 1 | Restrict operation to stage 0 |
| demux_en | input | 1 | Limit serial channel select to 0-15 |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 32 | Sample, one bit per channel |
| capture_start | output | 1 | One-cycle pulse: capture begins |
| trig_level | output | 2 | Current trigger level |

## Verification
A corrupt serial history or a wrong channel index shows up as a missing or early `capture_start`. It appears in the cycle after the sample that completes the pattern, so the bench builds bit sequences whose match point is known exactly. A delay counter that is off by one moves the pulse by one sample, and the level staying at 0 on the matching sample exposes a counter that acted too early. Stale per-stage state after re-arming, or a level that fails to gate a later stage, changes `trig_level` one cycle after the offending sample. The level is checked after every sample of the chained tests.

// File: rtl/stg_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the chained trigger.
// Assumes a 32-channel sample; field offsets follow the configuration word layout in the brief.
package stg_pkg;
    localparam int SMP_W    = 32;
    localparam int CH_W     = $clog2(SMP_W);
    localparam int DLY_W    = 16;
    localparam int LVL_W    = 2;
    localparam int F_LVL_LO = 16;
    localparam int F_CH_LO  = 20;
    localparam int F_SER    = 26;
    localparam int F_START  = 27;

    typedef enum logic [1:0] {
        SEL_MASK  = 2'd0,
        SEL_VALUE = 2'd1,
        SEL_CONF  = 2'd2
    } cfg_sel_e;

    typedef struct packed {
        logic [SMP_W-1:0] mask;
        logic [SMP_W-1:0] value;
        logic [DLY_W-1:0] delay;
        logic [LVL_W-1:0] level;
        logic [CH_W-1:0]  chan;
        logic             serial;
        logic             start;
    } stage_cfg_t;
endpackage

// File: rtl/stg_cfg_regs.sv
`timescale 1ns/1ps
// Per-stage configuration storage, written one register at a time.
// Assumes at most one write per cycle; unknown select codes are dropped.
module stg_cfg_regs
    import stg_pkg::*;
#(
    parameter int NUM_STAGES = 4,
    localparam int IDX_W = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] stage,
    input  logic [1:0]       sel,
    input  logic [SMP_W-1:0] data,
    output stage_cfg_t       cfg_o [NUM_STAGES]
);
    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_reg
        // Load the addressed field of this stage.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_o[g] <= '0;
            end else if (we && stage == IDX_W'(g)) begin
                case (cfg_sel_e'(sel))
                    SEL_MASK:  cfg_o[g].mask  <= data;
                    SEL_VALUE: cfg_o[g].value <= data;
                    SEL_CONF: begin
                        cfg_o[g].delay  <= data[DLY_W-1:0];
                        cfg_o[g].level  <= data[F_LVL_LO +: LVL_W];
                        cfg_o[g].chan   <= data[F_CH_LO +: CH_W];
                        cfg_o[g].serial <= data[F_SER];
                        cfg_o[g].start  <= data[F_START];
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/stg_match.sv
`timescale 1ns/1ps
// Pattern comparator of one stage: parallel across channels or serial over one channel's history.
// Assumes the history shifts on every valid sample, armed or not; newest bit lands in bit 0.
module stg_match
    import stg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [SMP_W-1:0] smp,
    input  logic             demux_en,
    input  stage_cfg_t       cfg,
    output logic             match
);
    localparam logic [CH_W-1:0] DEMUX_KEEP = {1'b0, {(CH_W-1){1'b1}}};

    logic [SMP_W-1:0] hist_q;
    logic [SMP_W-1:0] hist_nxt;
    logic [SMP_W-1:0] src;
    logic [CH_W-1:0]  eff_ch;

    assign eff_ch   = demux_en ? (cfg.chan & DEMUX_KEEP) : cfg.chan;
    assign hist_nxt = {hist_q[SMP_W-2:0], smp[eff_ch]};
    assign src      = cfg.serial ? hist_nxt : smp;
    assign match    = ((src ^ cfg.value) & cfg.mask) == '0;

    // Shift the selected channel into the history on each sample.
    always_ff @(posedge clk) begin
        if (!rst_n)    hist_q <= '0;
        else if (step) hist_q <= hist_nxt;
    end
endmodule

// File: rtl/stg_delay.sv
`timescale 1ns/1ps
// Holds back one stage's action by its programmed sample count and remembers that it matched.
// Assumes hit is only raised while busy is low, so a pending count is never reloaded.
module stg_delay
    import stg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic             hit,
    input  logic [DLY_W-1:0] delay,
    output logic             fire,
    output logic             busy
);
    logic             pend_q;
    logic             done_q;
    logic [DLY_W-1:0] cnt_q;

    assign fire = step && ((hit && delay == '0) || (pend_q && cnt_q == DLY_W'(1)));
    assign busy = done_q;

    // Track match, pending delay and remaining sample count.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            pend_q <= 1'b0;
            done_q <= 1'b0;
            cnt_q  <= '0;
        end else if (step) begin
            if (hit) begin
                done_q <= 1'b1;
                if (delay != '0) begin
                    pend_q <= 1'b1;
                    cnt_q  <= delay;
                end
            end else if (pend_q) begin
                if (cnt_q == DLY_W'(1)) pend_q <= 1'b0;
                else                    cnt_q  <= cnt_q - DLY_W'(1);
            end
        end
    end
endmodule

// File: rtl/stage_trigger.sv
`timescale 1ns/1ps
// Chained multi-stage trigger: stages gated by a shared level, each raising it when it acts;
// a stage with its start flag set ends the search with a one-cycle capture pulse.
// Assumes arm is a single-cycle command pulse and takes priority over a sample in the same cycle.
module stage_trigger
    import stg_pkg::*;
#(
    parameter int NUM_STAGES = 4,
    localparam int IDX_W = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_stage,
    input  logic [1:0]       cfg_sel,
    input  logic [SMP_W-1:0] cfg_data,
    input  logic             arm,
    input  logic             proto_v0,
    input  logic             demux_en,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp_data,
    output logic             capture_start,
    output logic [LVL_W-1:0] trig_level
);
    localparam logic [LVL_W-1:0] LVL_MAX = '1;

    stage_cfg_t            cfg [NUM_STAGES];
    logic [NUM_STAGES-1:0] match, hit, fire, busy, act, start_en;
    logic                  armed_q, fired_q, cap_q;
    logic [LVL_W-1:0]      level_q;
    logic                  live;

    assign live = armed_q && !fired_q && !arm;

    stg_cfg_regs #(.NUM_STAGES(NUM_STAGES)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .stage (cfg_stage),
        .sel   (cfg_sel),
        .data  (cfg_data),
        .cfg_o (cfg)
    );

    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
        localparam bit IS_FIRST = (g == 0);
        logic enabled;

        assign enabled = IS_FIRST || !proto_v0;

        stg_match u_match (
            .clk      (clk),
            .rst_n    (rst_n),
            .step     (smp_valid),
            .smp      (smp_data),
            .demux_en (demux_en),
            .cfg      (cfg[g]),
            .match    (match[g])
        );

        assign hit[g] = smp_valid && live && enabled && !busy[g]
                        && (level_q >= cfg[g].level) && match[g];

        stg_delay u_delay (
            .clk   (clk),
            .rst_n (rst_n),
            .clear (arm),
            .step  (smp_valid),
            .hit   (hit[g]),
            .delay (cfg[g].delay),
            .fire  (fire[g]),
            .busy  (busy[g])
        );

        assign act[g]      = fire[g] && live;
        assign start_en[g] = cfg[g].start;
    end

    // Arming state, shared level, one-shot latch and the registered start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            fired_q <= 1'b0;
            cap_q   <= 1'b0;
            level_q <= '0;
        end else if (arm) begin
            armed_q <= 1'b1;
            fired_q <= 1'b0;
            cap_q   <= 1'b0;
            level_q <= '0;
        end else begin
            cap_q <= |(act & start_en);
            if (|(act & start_en)) fired_q <= 1'b1;
            if (|act && level_q != LVL_MAX) level_q <= level_q + LVL_W'(1);
        end
    end

    assign capture_start = cap_q;
    assign trig_level    = level_q;
endmodule

// File: rtl/stage_trigger_chk.sv
`timescale 1ns/1ps
// Port-level protocol checks for the chained trigger, attached by bind.
// Assumes the default two-bit level.
module stage_trigger_chk
    import stg_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             arm,
    input logic             smp_valid,
    input logic             capture_start,
    input logic [LVL_W-1:0] trig_level
);
    p_arm_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (trig_level == '0 && !capture_start));

    p_level_no_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> (trig_level >= $past(trig_level)));

    p_level_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> ({1'b0, trig_level} <= {1'b0, $past(trig_level)} + 1'b1));

    p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_valid && !arm) |=> ($stable(trig_level) && !capture_start));

    p_one_shot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        capture_start |=> !capture_start);
endmodule

bind stage_trigger stage_trigger_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .arm           (arm),
    .smp_valid     (smp_valid),
    .capture_start (capture_start),
    .trig_level    (trig_level)
);

// File: tb/stage_trigger_bench.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results at the ports.
module stage_trigger_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_stage = '0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_data = '0;
    logic        arm = 1'b0;
    logic        proto_v0 = 1'b0;
    logic        demux_en = 1'b0;
    logic        smp_valid = 1'b0;
    logic [31:0] smp_data = '0;
    logic        capture_start;
    logic [1:0]  trig_level;

    int n_run = 0;
    int n_fail = 0;
    logic       got_cap;
    logic [1:0] got_lvl;

    always #5 clk = ~clk;

    stage_trigger u_stage_trigger (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_stage(cfg_stage),
        .cfg_sel(cfg_sel), .cfg_data(cfg_data), .arm(arm), .proto_v0(proto_v0),
        .demux_en(demux_en), .smp_valid(smp_valid), .smp_data(smp_data),
        .capture_start(capture_start), .trig_level(trig_level)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic expect_out(input string tag, input logic ecap, input logic [1:0] elvl);
        check(got_cap == ecap, {tag, " capture_start"}, {31'b0, got_cap}, {31'b0, ecap});
        check(got_lvl == elvl, {tag, " trig_level"}, {30'b0, got_lvl}, {30'b0, elvl});
    endtask

    function automatic logic [31:0] mkconf(input int dly, input int lvl, input int ch, input bit ser, input bit st);
        return (32'(dly) & 32'hFFFF) | (32'(lvl) << 16) | (32'(ch) << 20)
               | (32'(ser) << 26) | (32'(st) << 27);
    endfunction

    task automatic wreg(input int s, input int sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_stage = 2'(s); cfg_sel = 2'(sel); cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // R13: select 0 mask, 1 value, 2 configuration
    task automatic setup(input int s, input logic [31:0] m, input logic [31:0] v, input logic [31:0] c);
        wreg(s, 0, m);
        wreg(s, 1, v);
        wreg(s, 2, c);
    endtask

    task automatic park_all();
        for (int s = 0; s < 4; s++) setup(s, 32'hFFFF_FFFF, 32'hDEAD_BEEF, mkconf(0, 3, 0, 0, 0));
    endtask

    task automatic do_arm();
        @(negedge clk);
        arm = 1'b1;
        @(posedge clk);
        #1;
        arm = 1'b0;
        got_cap = capture_start;
        got_lvl = trig_level;
    endtask

    task automatic push(input logic [31:0] d);
        @(negedge clk);
        smp_valid = 1'b1; smp_data = d;
        @(posedge clk);
        #1;
        smp_valid = 1'b0;
        got_cap = capture_start;
        got_lvl = trig_level;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            got_cap = capture_start;
            got_lvl = trig_level;
        end
    endtask

    task automatic t_reset();
        got_cap = capture_start; got_lvl = trig_level;
        expect_out("R1 reset state", 1'b0, 2'd0);
        park_all();
        setup(0, 32'h0, 32'h0, mkconf(0, 0, 0, 0, 1));
        push(32'h1);
        expect_out("R1 unarmed sample", 1'b0, 2'd0);
    endtask

    task automatic t_parallel();
        park_all();
        setup(0, 32'h0000_00FF, 32'h0000_005A, mkconf(0, 0, 0, 0, 1));
        do_arm();
        push(32'h0000_005B);
        expect_out("R2 masked bit differs", 1'b0, 2'd0);
        push(32'h1234_565A);
        expect_out("R2 masked bits equal", 1'b1, 2'd1);
        push(32'h0000_005A);
        expect_out("R9 ignored after start", 1'b0, 2'd1);
        do_arm();
        expect_out("R8 arm clears level", 1'b0, 2'd0);
    endtask

    task automatic t_chain();
        park_all();
        setup(0, 32'hFF, 32'h01, mkconf(0, 0, 0, 0, 0));
        setup(1, 32'hFF, 32'h02, mkconf(0, 1, 0, 0, 1));
        do_arm();
        push(32'h02);
        expect_out("R6 stage1 below level", 1'b0, 2'd0);
        push(32'h01);
        expect_out("R7 no start flag raises level", 1'b0, 2'd1);
        push(32'h01);
        expect_out("R6 stage0 matches once", 1'b0, 2'd1);
        push(32'h02);
        expect_out("R7 start flag pulses", 1'b1, 2'd2);
    endtask

    task automatic t_serial();
        park_all();
        // R3: channel 3, pattern newest=1, older=0, oldest=1
        setup(0, 32'h7, 32'h5, mkconf(0, 0, 3, 1, 1));
        do_arm();
        push(32'h0); push(32'h0); push(32'h0);
        push(32'h8);
        expect_out("R3 history 001", 1'b0, 2'd0);
        push(32'h0);
        expect_out("R3 history 010", 1'b0, 2'd0);
        push(32'h8);
        expect_out("R3 history 101", 1'b1, 2'd1);
    endtask

    task automatic t_demux();
        park_all();
        setup(0, 32'h1, 32'h1, mkconf(0, 0, 19, 1, 1));
        demux_en = 1'b1;
        do_arm();
        push(32'h0008_0000);
        expect_out("R4 channel 19 ignored", 1'b0, 2'd0);
        push(32'h0000_0008);
        expect_out("R4 folds to channel 3", 1'b1, 2'd1);
        demux_en = 1'b0;
    endtask

    task automatic t_delay();
        park_all();
        setup(0, 32'hFF, 32'h33, mkconf(3, 0, 0, 0, 1));
        do_arm();
        push(32'h33);
        expect_out("R5 held on match", 1'b0, 2'd0);
        push(32'h0);
        expect_out("R5 one sample after", 1'b0, 2'd0);
        idle(4);
        expect_out("R12 idle cycles hold", 1'b0, 2'd0);
        push(32'h0);
        expect_out("R5 two samples after", 1'b0, 2'd0);
        push(32'h0);
        expect_out("R5 acts on third sample", 1'b1, 2'd1);
    endtask

    task automatic t_zero_mask();
        park_all();
        setup(0, 32'h0, 32'hFFFF_FFFF, mkconf(0, 0, 0, 0, 1));
        do_arm();
        push(32'h0BAD_F00D);
        expect_out("R11 zero mask first sample", 1'b1, 2'd1);
    endtask

    task automatic t_proto0();
        park_all();
        setup(0, 32'hFF, 32'h01, mkconf(0, 0, 0, 0, 0));
        setup(1, 32'h0, 32'h0, mkconf(0, 1, 0, 0, 1));
        proto_v0 = 1'b1;
        do_arm();
        push(32'h01);
        expect_out("R10 stage0 active", 1'b0, 2'd1);
        push(32'h77);
        expect_out("R10 stage1 disabled", 1'b0, 2'd1);
        proto_v0 = 1'b0;
        push(32'h77);
        expect_out("R10 stage1 re-enabled", 1'b1, 2'd2);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_parallel();
        t_chain();
        t_serial();
        t_demux();
        t_delay();
        t_zero_mask();
        t_proto0();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule